// File: doc/BRIEF.md
# Alignment Trap Entry Unit

This unit performs the register side of taking an alignment trap. When a data access is found to be misaligned, the pipeline raises a single-cycle trap strobe. With it, the pipeline presents the faulting instruction's address and encoding, an addressing-form flag, the effective data address, and the current machine state word. On that same clock edge the unit loads five registers:

- a saved program counter;
- a saved copy of part of the state word;
- the state word the handler will run under;
- a fault status word built from slices of the instruction;
- the fault address.

In the following cycle it raises a one-cycle redirect pulse, which the fetch logic uses to enter the handler.

A small combinational checker sits beside the register logic. It reports word accesses whose two lowest address bits are nonzero. It also reports the case where such an access comes from a load-reserve or store-conditional word operation. That case is still trapped, but the handler should treat it as a program bug rather than emulate it. The flag is captured with the rest of the trap state so the handler can read it.

All bit numbers in this brief are big-endian: bit 0 is the most significant bit of a 32-bit word. The RTL vectors are little-endian, so big-endian bit b is vector index 31-b. Every port is a plain control or data pin. There is no back-pressure: the strobe is always accepted in the cycle it is high.

Top module: `align_trap_unit`

## Requirements
- R1: While reset is low, and after it is released, the saved PC, saved state, next state, fault status, fault address, programming-error flag and redirect all read zero until the first strobe.
- R2: On a clock edge with the strobe high, the saved PC takes the faulting instruction address and the fault address takes the data effective address.
- R3: On a strobe, saved-state bits 0–15 become zero and bits 16–31 copy state-word bits 16–31.
- R4: On a strobe, the next state keeps bits 15 (trap-endian), 19 (machine-check enable) and 25 (vector prefix) of the current state word. Bit 31 (endian mode) takes the value of bit 15. Every other bit is zero.
- R5: On a strobe, fault-status bits 0–14 are zero. In both addressing forms, status bits 22–26 copy instruction bits 6–10 and status bits 27–31 copy instruction bits 11–15.
- R6: For the indexed form (flag = 1), status bits 15–16 copy instruction bits 29–30, status bit 17 copies instruction bit 25, and status bits 18–21 copy instruction bits 21–24.
- R7: For the immediate-offset form (flag = 0), status bits 15–16 are zero, status bit 17 copies instruction bit 5, and status bits 18–21 copy instruction bits 1–4.
- R8: In a cycle without the strobe, all captured registers keep their values whatever the other inputs do.
- R9: The redirect output is high in exactly the cycle after each strobe edge and low in every other cycle. Strobes on consecutive cycles give consecutive redirect cycles.
- R10: The misaligned output is combinationally high exactly when the word-access input is high and data-address bits 30–31 are not both zero.
- R11: The reserve-misaligned output is high exactly when misaligned and the reserve-operation input are both high. A strobe still captures every register in that case, and also loads this value into the programming-error flag, which holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_stb_i | input | 1 | One-cycle alignment trap strobe |
| fault_pc_i | input | 32 | Address of the faulting instruction |
| fault_instr_i | input | 32 | Encoding of the faulting instruction |
| indexed_form_i | input | 1 | 1 = indexed addressing, 0 = immediate-offset |
| data_ea_i | input | 32 | Effective data address computed by the instruction |
| state_i | input | 32 | Current machine state word |
| word_access_i | input | 1 | The access is a word access |
| reserve_op_i | input | 1 | The access is a load-reserve or store-conditional word |
| misaligned_o | output | 1 | Word access with nonzero low address bits |
| resv_misaligned_o | output | 1 | Misaligned reserve/conditional access |
| save_pc_o | output | 32 | Saved program counter |
| save_state_o | output | 32 | Saved partial state word |
| state_next_o | output | 32 | State word for the handler |
| fault_status_o | output | 32 | Fault status word |
| fault_addr_o | output | 32 | Faulting data address |
| trap_prog_err_o | output | 1 | Captured reserve-misaligned flag |
| redirect_o | output | 1 | One-cycle pulse after a strobe |

## Verification
The hardest thing to show from the ports is that every instruction bit lands in the right status position in each addressing form, and in no other position. Random encodings would rarely isolate a single misrouted bit. The bench therefore sends a walking single one through all 32 instruction bit positions, once for each form, and compares each captured status word against a value built from shifts and masks. A second walking-one sweep over the state word does the same for the saved and next state words. The bench also drives strobes on back-to-back cycles and misaligned reserve accesses at the moment of the strobe.

// File: rtl/align_trap_pkg.sv
package align_trap_pkg;

  localparam int WORD_W   = 32;
  localparam int ALIGN_W  = 2;
  localparam int HALF_W   = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;

  // big-endian bit number -> vector index
  function automatic int be(input int b);
    return WORD_W - 1 - b;
  endfunction

  // state-word bit positions (big-endian)
  localparam int ST_TRAP_ENDIAN = 15;
  localparam int ST_MCHK_EN     = 19;
  localparam int ST_VEC_PREFIX  = 25;
  localparam int ST_ENDIAN      = 31;

  // fault-status field positions (big-endian)
  localparam int FS_IDX_LO    = 15;  // two bits
  localparam int FS_UPD_BIT   = 17;
  localparam int FS_OPC_LO    = 18;  // four bits
  localparam int FS_REG_LO    = 22;  // five bits
  localparam int FS_BASE_LO   = 27;  // five bits
  localparam int FS_CLEAR_TOP = 14;  // bits 0..14 zero

  // instruction sources, indexed form
  localparam int IX_IDX_SRC = 29;
  localparam int IX_UPD_SRC = 25;
  localparam int IX_OPC_SRC = 21;
  // instruction sources, immediate-offset form
  localparam int IM_UPD_SRC = 5;
  localparam int IM_OPC_SRC = 1;
  // shared sources
  localparam int REG_SRC  = 6;
  localparam int BASE_SRC = 11;

  localparam int IDX_W  = 2;
  localparam int OPC_W  = 4;
  localparam int REG_W  = 5;

endpackage

// File: rtl/atu_misalign_check.sv
module atu_misalign_check
  import align_trap_pkg::*;
#(
  parameter int LOW_W = ALIGN_W
) (
  input  logic [LOW_W-1:0] ea_low_i,
  input  logic             word_access_i,
  input  logic             reserve_op_i,
  output logic             misaligned_o,
  output logic             resv_fault_o
);

  logic off_boundary;

  always_comb begin
    off_boundary = 1'b0;
    for (int i = 0; i < LOW_W; i++) begin
      off_boundary = off_boundary | ea_low_i[i];
    end
  end

  assign misaligned_o = word_access_i & off_boundary;
  assign resv_fault_o = misaligned_o & reserve_op_i;

  always_comb begin
    AST_RESV_SUBSET: assert (!resv_fault_o || misaligned_o)  // R11
      else $error("reserve fault without misalignment");
    if (ea_low_i == '0) begin
      AST_ALIGNED_QUIET: assert (!misaligned_o)  // R10
        else $error("aligned address flagged");
    end
  end

endmodule

// File: rtl/atu_status_build.sv
module atu_status_build
  import align_trap_pkg::*;
(
  input  word_t instr_i,
  input  logic  indexed_i,
  output word_t status_o
);

  logic unused_bits;
  assign unused_bits = ^{instr_i[be(0)], instr_i[be(16):be(20)],
                         instr_i[be(26):be(28)], instr_i[be(31)]};

  always_comb begin
    status_o = '0;
    // register fields, same in both forms
    for (int i = 0; i < REG_W; i++) begin
      status_o[be(FS_REG_LO + i)]  = instr_i[be(REG_SRC + i)];
      status_o[be(FS_BASE_LO + i)] = instr_i[be(BASE_SRC + i)];
    end
    if (indexed_i) begin
      for (int i = 0; i < IDX_W; i++) begin
        status_o[be(FS_IDX_LO + i)] = instr_i[be(IX_IDX_SRC + i)];
      end
      status_o[be(FS_UPD_BIT)] = instr_i[be(IX_UPD_SRC)];
      for (int i = 0; i < OPC_W; i++) begin
        status_o[be(FS_OPC_LO + i)] = instr_i[be(IX_OPC_SRC + i)];
      end
    end else begin
      status_o[be(FS_UPD_BIT)] = instr_i[be(IM_UPD_SRC)];
      for (int i = 0; i < OPC_W; i++) begin
        status_o[be(FS_OPC_LO + i)] = instr_i[be(IM_OPC_SRC + i)];
      end
    end
  end

endmodule

// File: rtl/atu_state_mask.sv
module atu_state_mask
  import align_trap_pkg::*;
(
  input  word_t state_i,
  output word_t save_o,
  output word_t next_o
);

  localparam word_t SAVE_MASK = word_t'((64'd1 << HALF_W) - 1);
  localparam word_t KEEP_MASK = (word_t'(1) << be(ST_TRAP_ENDIAN))
                              | (word_t'(1) << be(ST_MCHK_EN))
                              | (word_t'(1) << be(ST_VEC_PREFIX));

  word_t kept;

  assign save_o = state_i & SAVE_MASK;
  assign kept   = state_i & KEEP_MASK;

  always_comb begin
    next_o = kept;
    next_o[be(ST_ENDIAN)] = state_i[be(ST_TRAP_ENDIAN)];
  end

endmodule

// File: rtl/align_trap_unit.sv
module align_trap_unit
  import align_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_stb_i,
  input  logic [31:0] fault_pc_i,
  input  logic [31:0] fault_instr_i,
  input  logic        indexed_form_i,
  input  logic [31:0] data_ea_i,
  input  logic [31:0] state_i,
  input  logic        word_access_i,
  input  logic        reserve_op_i,
  output logic        misaligned_o,
  output logic        resv_misaligned_o,
  output logic [31:0] save_pc_o,
  output logic [31:0] save_state_o,
  output logic [31:0] state_next_o,
  output logic [31:0] fault_status_o,
  output logic [31:0] fault_addr_o,
  output logic        trap_prog_err_o,
  output logic        redirect_o
);

  word_t save_state_d, state_next_d, status_d;
  logic  resv_fault;

  atu_misalign_check #(.LOW_W(ALIGN_W)) u_check (
    .ea_low_i      (data_ea_i[ALIGN_W-1:0]),
    .word_access_i (word_access_i),
    .reserve_op_i  (reserve_op_i),
    .misaligned_o  (misaligned_o),
    .resv_fault_o  (resv_fault)
  );

  atu_status_build u_status (
    .instr_i   (fault_instr_i),
    .indexed_i (indexed_form_i),
    .status_o  (status_d)
  );

  atu_state_mask u_state (
    .state_i (state_i),
    .save_o  (save_state_d),
    .next_o  (state_next_d)
  );

  assign resv_misaligned_o = resv_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_pc_o       <= '0;
      save_state_o    <= '0;
      state_next_o    <= '0;
      fault_status_o  <= '0;
      fault_addr_o    <= '0;
      trap_prog_err_o <= 1'b0;
      redirect_o      <= 1'b0;
    end else begin
      redirect_o <= trap_stb_i;
      if (trap_stb_i) begin
        save_pc_o       <= fault_pc_i;
        save_state_o    <= save_state_d;
        state_next_o    <= state_next_d;
        fault_status_o  <= status_d;
        fault_addr_o    <= data_ea_i;
        trap_prog_err_o <= resv_fault;
      end
    end
  end

  AST_PC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb_i |=> save_pc_o == $past(fault_pc_i));  // R2
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb_i |=> fault_addr_o == $past(data_ea_i));  // R2
  AST_SAVE_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb_i |=> save_state_o[31:16] == '0);  // R3
  AST_SAVE_LOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb_i |=> save_state_o[15:0] == $past(state_i[15:0]));  // R3
  AST_ENDIAN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb_i |=> state_next_o[0] == $past(state_i[16]));  // R4
  AST_STATUS_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb_i |=> fault_status_o[31:17] == '0);  // R5
  AST_IMM_INDEX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_stb_i && !indexed_form_i) |=> fault_status_o[16:15] == '0);  // R7
  AST_IDX_FIELD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_stb_i && indexed_form_i) |=> fault_status_o[16:15] == $past(fault_instr_i[2:1]));  // R6
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_stb_i |=> ($stable(save_pc_o) && $stable(save_state_o) && $stable(state_next_o)
                     && $stable(fault_status_o) && $stable(fault_addr_o)
                     && $stable(trap_prog_err_o)));  // R8
  AST_REDIRECT_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb_i |=> redirect_o);  // R9
  AST_REDIRECT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_stb_i |=> !redirect_o);  // R9
  AST_PROG_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb_i |=> trap_prog_err_o == $past(resv_misaligned_o));  // R11

endmodule

// File: tb/tb_align_trap_unit.sv
module tb_align_trap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_stb_i = 1'b0;
  logic [31:0] fault_pc_i = '0;
  logic [31:0] fault_instr_i = '0;
  logic        indexed_form_i = 1'b0;
  logic [31:0] data_ea_i = '0;
  logic [31:0] state_i = '0;
  logic        word_access_i = 1'b0;
  logic        reserve_op_i = 1'b0;
  logic        misaligned_o, resv_misaligned_o, trap_prog_err_o, redirect_o;
  logic [31:0] save_pc_o, save_state_o, state_next_o, fault_status_o, fault_addr_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  align_trap_unit dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input logic [31:0] iw, input logic idx);
    logic [31:0] s;
    s = ((iw >> 16) & 32'h1F) | (((iw >> 21) & 32'h1F) << 5);
    if (idx) begin
      s |= ((iw >> 7) & 32'hF) << 10;
      s |= ((iw >> 6) & 32'h1) << 14;
      s |= ((iw >> 1) & 32'h3) << 15;
    end else begin
      s |= ((iw >> 27) & 32'hF) << 10;
      s |= ((iw >> 26) & 32'h1) << 14;
    end
    return s;
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] m);
    return (m & 32'h0001_1040) | ((m >> 16) & 32'h1);
  endfunction

  task automatic trap(input logic [31:0] pc, input logic [31:0] iw, input logic idx,
                      input logic [31:0] ea, input logic [31:0] m,
                      input logic wa, input logic rs);
    @(negedge clk);
    fault_pc_i = pc; fault_instr_i = iw; indexed_form_i = idx;
    data_ea_i = ea; state_i = m; word_access_i = wa; reserve_op_i = rs;
    trap_stb_i = 1'b1;
    @(negedge clk);
    trap_stb_i = 1'b0;
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] spc, sst, snx, sfs, sfa;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 save_pc in reset", save_pc_o, 0);
    chk("R1 redirect in reset", {31'b0, redirect_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 save_pc", save_pc_o, 0);
    chk("R1 save_state", save_state_o, 0);
    chk("R1 state_next", state_next_o, 0);
    chk("R1 fault_status", fault_status_o, 0);
    chk("R1 fault_addr", fault_addr_o, 0);
    chk("R1 prog_err", {31'b0, trap_prog_err_o}, 0);
    chk("R1 redirect", {31'b0, redirect_o}, 0);

    // R3/R4 walking one through the state word, plus R2 and R9
    for (int k = 0; k < 32; k++) begin
      trap(32'h1000_0000 + k * 4, 32'h0, 1'b0, 32'hA000_0001 ^ (k << 8), 32'h1 << k, 1'b0, 1'b0);
      chk("R2 save_pc", save_pc_o, 32'h1000_0000 + k * 4);
      chk("R2 fault_addr", fault_addr_o, 32'hA000_0001 ^ (k << 8));
      chk("R3 save_state", save_state_o, (32'h1 << k) & 32'h0000_FFFF);
      chk("R4 state_next", state_next_o, exp_next(32'h1 << k));
      chk("R9 redirect high", {31'b0, redirect_o}, 1);
      @(negedge clk);
      chk("R9 redirect low", {31'b0, redirect_o}, 0);
    end
    trap(32'h0, 32'h0, 1'b0, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    chk("R3 save_state all ones", save_state_o, 32'h0000_FFFF);
    chk("R4 state_next all ones", state_next_o, 32'h0001_1041);
    trap(32'h0, 32'h0, 1'b0, 32'h0, 32'hFFFE_FFFF, 1'b0, 1'b0);
    chk("R4 endian cleared", state_next_o, 32'h0000_1040);

    // R5/R6/R7 walking one through the instruction, both forms
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 32; k++) begin
        trap(32'h4, 32'h1 << k, f[0], 32'h8, 32'h0, 1'b1, 1'b0);
        chk(f ? "R6 walk indexed" : "R7 walk immediate", fault_status_o,
            exp_status(32'h1 << k, f[0]));
        chk("R5 top clear", fault_status_o & 32'hFFFE_0000, 0);
      end
    end
    // pattern sweep
    for (int k = 0; k < 48; k++) begin
      logic [31:0] iw;
      iw = (k + 1) * 32'h9E37_79B9;
      trap(iw, iw, k[0], ~iw, iw ^ 32'h5A5A_A5A5, 1'b0, 1'b0);
      chk(k[0] ? "R6 pattern" : "R7 pattern", fault_status_o, exp_status(iw, k[0]));
      chk("R5 pattern regs", fault_status_o & 32'h3FF, (iw >> 16) & 32'h3FF);
    end

    // R8 hold with changing inputs and no strobe
    trap(32'hCAFE_0000, 32'h7C00_002E, 1'b1, 32'h0000_0003, 32'h0001_9040, 1'b1, 1'b1);
    spc = save_pc_o; sst = save_state_o; snx = state_next_o;
    sfs = fault_status_o; sfa = fault_addr_o;
    chk("R11 prog_err captured", {31'b0, trap_prog_err_o}, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fault_pc_i = ~fault_pc_i; fault_instr_i = ~fault_instr_i; data_ea_i = k;
      state_i = ~state_i; indexed_form_i = ~indexed_form_i; reserve_op_i = 1'b0;
      @(negedge clk);
      chk("R8 hold save_pc", save_pc_o, spc);
      chk("R8 hold save_state", save_state_o, sst);
      chk("R8 hold state_next", state_next_o, snx);
      chk("R8 hold status", fault_status_o, sfs);
      chk("R8 hold addr", fault_addr_o, sfa);
      chk("R11 prog_err held", {31'b0, trap_prog_err_o}, 1);
    end

    // R10/R11 exhaustive checker sweep
    for (int lo = 0; lo < 4; lo++) begin
      for (int w = 0; w < 2; w++) begin
        for (int r = 0; r < 2; r++) begin
          logic em, er;
          @(negedge clk);
          data_ea_i = 32'h0000_1230 | lo; word_access_i = w[0]; reserve_op_i = r[0];
          #1;
          em = w[0] && (lo != 0);
          er = em && r[0];
          chk("R10 misaligned", {31'b0, misaligned_o}, {31'b0, em});
          chk("R11 resv_misaligned", {31'b0, resv_misaligned_o}, {31'b0, er});
          trap(32'h2000 + lo, 32'h0, 1'b0, 32'h0000_1230 | lo, 32'h0, w[0], r[0]);
          chk("R11 prog_err on strobe", {31'b0, trap_prog_err_o}, {31'b0, er});
          chk("R11 addr still captured", fault_addr_o, 32'h0000_1230 | lo);
        end
      end
    end

    // R9 back-to-back strobes
    @(negedge clk);
    fault_pc_i = 32'h111; trap_stb_i = 1'b1;
    @(negedge clk);
    chk("R9 b2b first redirect", {31'b0, redirect_o}, 1);
    fault_pc_i = 32'h222;
    @(negedge clk);
    trap_stb_i = 1'b0;
    chk("R9 b2b second redirect", {31'b0, redirect_o}, 1);
    chk("R2 b2b second pc", save_pc_o, 32'h222);
    @(negedge clk);
    chk("R9 b2b end", {31'b0, redirect_o}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule